// File: doc/BRIEF.md
# Single-Precision Round-and-Pack Unit

This combinational unit turns an unrounded floating-point value into a finished 32-bit single-precision word. The caller supplies a sign, a 16-bit two's-complement exponent and a 32-bit significand. The exponent is one less than the biased exponent of the result. The significand keeps its leading one at bit 30, and its binary point is seven places to the left of where the packed fraction puts it. The unit rounds the value under one of four rounding modes. It saturates values that are too large, and it handles values that are too small. It also reports overflow, underflow, inexact and whether the magnitude was rounded up.

For tiny values there are three paths. With underflow masked, the significand is shifted right into the subnormal range and the lost bits are ORed into the sticky bit. A flush-to-zero option replaces that result with a signed zero. With underflow unmasked, the exponent is raised by a fixed bias of 192 instead, so the caller receives a scaled normal result. Tininess is judged before rounding. NaN handling and the arithmetic that produces the unrounded value are left to the caller.

Top module: `sp_round_pack`

## Requirements
- R1: The rounding mode encoding is 0 for nearest-even, 1 for toward minus infinity, 2 for toward plus infinity and 3 for toward zero. The round increment added to the seven low significand bits is 0x40 for nearest-even and 0 for toward-zero. In the two directed modes it is 0x7F when the mode points away from zero for the given sign, and 0 when it points toward zero.
- R2: On the normal path the result is {sign, 31'b0} + {exponent, 23'b0} + ((significand + increment) >> 7), added as plain 32-bit words, so a carry out of the rounded significand raises the exponent field by one.
- R3: Under nearest-even, when the seven low bits equal exactly 0x40, the LSB of the rounded significand is cleared.
- R4: The unit signals overflow when the exponent is above 0xFD, or when it equals 0xFD and significand + increment sets bit 31. The result is then infinity (exponent field 0xFF, zero fraction) when the increment is nonzero, and the largest finite magnitude (0x7F7FFFFF with the sign) when the increment is zero. Underflow is never flagged together with overflow.
- R5: On overflow, inexact is set when the seven low bits are nonzero or overflow is masked. Rounded-up is set when inexact is set and the increment is nonzero.
- R6: For a negative exponent the value counts as tiny when the exponent is below -1, or when significand + increment stays below 0x80000000. Tininess is judged before rounding.
- R7: When a tiny value meets unmasked underflow, the unit sets underflow and adds 192 to the exponent. If the exponent is then zero or above, the value is rounded as a normal number.
- R8: If the exponent is still negative, the significand is shifted right by the negated exponent. Every shifted-out bit is ORed into bit 0, even for shifts of 32 or more. The exponent becomes 0 and the round bits are taken again after the shift.
- R9: For a tiny value that is masked and not flushed, underflow is set only when the round bits after the shift are nonzero.
- R10: For a tiny, shifted value with flush-to-zero enabled, the result is a zero with the input sign, and both underflow and inexact are set.
- R11: On the normal path, inexact equals "round bits nonzero". Rounded-up is set when inexact is set and the rounded significand shifted left by 7 exceeds the pre-round significand.
- R12: When the rounded significand is zero, the exponent field of the result is forced to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_sign | input | 1 | Sign of the unrounded value |
| in_exp | input | 16 | Two's-complement exponent, one below the biased result exponent |
| in_sig | input | 32 | Significand, leading one at bit 30, seven extra low bits |
| rnd_mode | input | 2 | Rounding mode (0 nearest-even, 1 toward -inf, 2 toward +inf, 3 toward zero) |
| unf_mask | input | 1 | 1 masks underflow (denormalize), 0 unmasks it (bias exponent) |
| ovf_mask | input | 1 | 1 masks overflow, which forces inexact on overflow |
| ftz_en | input | 1 | Flush masked tiny results to signed zero |
| result | output | 32 | Packed single-precision word |
| ovf_flag | output | 1 | Overflow |
| unf_flag | output | 1 | Underflow |
| inx_flag | output | 1 | Inexact |
| rup_flag | output | 1 | Magnitude was rounded up |

## Verification
The bench targets the following corner cases:
- An exact halfway point under nearest-even, with the kept LSB both even and odd. A design that forgot the tie clear would round 0x40000040 up to 0x3F800001.
- A carry out of the rounded significand into the exponent field. A design without the carry would give 1.0 where 2.0 is due.
- The overflow boundary at exponent 0xFD, for both infinity and largest-finite saturation, with and without the overflow mask. A wrong boundary or a missing inexact shows up in the flags.
- Tininess at exponent -1. A pre-round value of 0x7FFFFFC0 must not be called tiny, so a design that judged tininess after the shift would wrongly flag underflow.
- Shifts of one bit and of far more than 32 bits. A design that lost the sticky bit on a long shift would report an exact zero instead of the smallest subnormal.
- The unmasked bias of 192, both when the biased exponent is non-negative and when it stays negative and still needs the shift. A wrong bias moves the exponent field away from 0xC0.

// File: rtl/sprp_pkg.sv
package sprp_pkg;
   typedef enum logic [1:0] {
      RM_NEAR_EVEN = 2'd0,
      RM_TO_NEG    = 2'd1,
      RM_TO_POS    = 2'd2,
      RM_TO_ZERO   = 2'd3
   } rmode_e;
endpackage

// File: rtl/sprp_inc_sel.sv
module sprp_inc_sel
   import sprp_pkg::*;
#(
   parameter int RND_W = 7
) (
   input  rmode_e             mode,
   input  logic               sign,
   output logic [RND_W-1:0]   inc,
   output logic               near_even
);
   localparam logic [RND_W-1:0] HALF = {1'b1, {(RND_W-1){1'b0}}};
   localparam logic [RND_W-1:0] FULL = {RND_W{1'b1}};

   always_comb begin
      near_even = (mode == RM_NEAR_EVEN);
      unique case (mode)
         RM_NEAR_EVEN: inc = HALF;
         RM_TO_ZERO:   inc = '0;
         RM_TO_POS:    inc = sign ? '0 : FULL;
         RM_TO_NEG:    inc = sign ? FULL : '0;
         default:      inc = '0;
      endcase
   end
endmodule

// File: rtl/sprp_jam_shift.sv
module sprp_jam_shift #(
   parameter int W     = 32,
   parameter int CNT_W = 16
) (
   input  logic [W-1:0]     din,
   input  logic [CNT_W-1:0] cnt,
   output logic [W-1:0]     dout
);
   localparam int LOG_W = $clog2(W);

   if ((1 << LOG_W) != W) begin : g_bad_w
      $error("sprp_jam_shift: W must be a power of two");
   end
   if (CNT_W <= LOG_W) begin : g_bad_cnt
      $error("sprp_jam_shift: CNT_W too narrow");
   end

   logic [W-1:0] stage [0:LOG_W];
   logic         huge;

   assign stage[0] = din;
   assign huge     = |cnt[CNT_W-1:LOG_W];

   for (genvar k = 0; k < LOG_W; k++) begin : g_stage
      localparam int SH = 1 << k;
      always_comb begin
         if (cnt[k])
            stage[k+1] = (stage[k] >> SH) |
                         {{(W-1){1'b0}}, |stage[k][SH-1:0]};
         else
            stage[k+1] = stage[k];
      end
   end

   assign dout = huge ? {{(W-1){1'b0}}, |din} : stage[LOG_W];
endmodule

// File: rtl/sprp_range.sv
module sprp_range #(
   parameter int EXP_W    = 16,
   parameter int SIG_W    = 32,
   parameter int RND_W    = 7,
   parameter int OVF_EXP  = 253,
   parameter int BIAS_ADJ = 192
) (
   input  logic [EXP_W-1:0] exp_in,
   input  logic [SIG_W-1:0] sig_in,
   input  logic [RND_W-1:0] inc,
   input  logic             unf_mask,
   input  logic             ftz_en,
   output logic             ovf,
   output logic             flush,
   output logic             unf,
   output logic [EXP_W-1:0] exp_adj,
   output logic [SIG_W-1:0] sig_adj
);
   localparam logic [EXP_W-1:0]        OVF_E  = EXP_W'(OVF_EXP);
   localparam logic [EXP_W-1:0]        BIAS_E = EXP_W'(BIAS_ADJ);
   localparam logic signed [EXP_W-1:0] NEG1   = -1;

   logic [SIG_W-1:0] sum;
   logic             special, neg, tiny, do_bias, need_shift;
   logic [EXP_W-1:0] exp_b, shamt;
   logic [SIG_W-1:0] shifted;

   assign sum     = sig_in + {{(SIG_W-RND_W){1'b0}}, inc};
   assign special = (exp_in >= OVF_E);
   assign neg     = exp_in[EXP_W-1];

   assign ovf = special && !neg &&
                ((exp_in > OVF_E) || ((exp_in == OVF_E) && sum[SIG_W-1]));

   assign tiny    = neg && (($signed(exp_in) < NEG1) || !sum[SIG_W-1]);
   assign do_bias = tiny && !unf_mask;
   assign exp_b   = do_bias ? (exp_in + BIAS_E) : exp_in;

   assign need_shift = neg && exp_b[EXP_W-1];
   assign shamt      = -exp_b;

   sprp_jam_shift #(.W(SIG_W), .CNT_W(EXP_W)) u_shift (
      .din  (sig_in),
      .cnt  (shamt),
      .dout (shifted)
   );

   assign sig_adj = need_shift ? shifted : sig_in;
   assign exp_adj = need_shift ? '0 : exp_b;
   assign flush   = need_shift && tiny && ftz_en;
   assign unf     = do_bias ||
                    (need_shift && tiny && (ftz_en || (|shifted[RND_W-1:0])));
endmodule

// File: rtl/sprp_pack.sv
module sprp_pack #(
   parameter int EXP_W  = 16,
   parameter int SIG_W  = 32,
   parameter int RND_W  = 7,
   parameter int FRAC_W = 23,
   parameter int PK_W   = 32
) (
   input  logic             sign,
   input  logic [EXP_W-1:0] exp_adj,
   input  logic [SIG_W-1:0] sig_adj,
   input  logic [RND_W-1:0] inc,
   input  logic             near_even,
   output logic [PK_W-1:0]  packed_word,
   output logic             inexact,
   output logic             rounded_up
);
   localparam int SR_W = SIG_W - RND_W;
   localparam int EF_W = PK_W - FRAC_W;
   localparam logic [RND_W-1:0] HALF = {1'b1, {(RND_W-1){1'b0}}};

   logic [RND_W-1:0] rbits;
   logic [SIG_W-1:0] sum;
   logic [SR_W-1:0]  sr_raw, sr;
   logic             tie;
   logic [EXP_W-1:0] exp_f;

   assign rbits  = sig_adj[RND_W-1:0];
   assign sum    = sig_adj + {{(SIG_W-RND_W){1'b0}}, inc};
   assign sr_raw = sum[SIG_W-1:RND_W];
   assign tie    = near_even && (rbits == HALF);
   assign sr     = sr_raw & ~{{(SR_W-1){1'b0}}, tie};
   assign exp_f  = (sr == '0) ? '0 : exp_adj;

   assign packed_word = {sign, {(PK_W-1){1'b0}}}
                      + {exp_f[EF_W-1:0], {FRAC_W{1'b0}}}
                      + {{(PK_W-SR_W){1'b0}}, sr};

   assign inexact    = |rbits;
   assign rounded_up = inexact && ({sr, {RND_W{1'b0}}} > sig_adj);
endmodule

// File: rtl/sp_round_pack.sv
module sp_round_pack
   import sprp_pkg::*;
#(
   parameter int EXP_W  = 16,
   parameter int SIG_W  = 32,
   parameter int EXPF_W = 8,
   parameter int FRAC_W = 23
) (
   input  logic              in_sign,
   input  logic [EXP_W-1:0]  in_exp,
   input  logic [SIG_W-1:0]  in_sig,
   input  logic [1:0]        rnd_mode,
   input  logic              unf_mask,
   input  logic              ovf_mask,
   input  logic              ftz_en,
   output logic [31:0]       result,
   output logic              ovf_flag,
   output logic              unf_flag,
   output logic              inx_flag,
   output logic              rup_flag
);
   localparam int PK_W     = 1 + EXPF_W + FRAC_W;
   localparam int RND_W    = SIG_W - FRAC_W - 2;
   localparam int OVF_EXP  = (1 << EXPF_W) - 3;
   localparam int BIAS_ADJ = 3 << (EXPF_W - 2);

   if (PK_W != 32) begin : g_bad_pk
      $error("sp_round_pack: packed word must be 32 bits");
   end
   if (RND_W < 2) begin : g_bad_rnd
      $error("sp_round_pack: too few round bits");
   end
   if (EXP_W <= EXPF_W) begin : g_bad_exp
      $error("sp_round_pack: exponent input too narrow");
   end

   logic [RND_W-1:0] inc;
   logic             near_even;
   logic             r_ovf, r_flush, r_unf;
   logic [EXP_W-1:0] exp_adj;
   logic [SIG_W-1:0] sig_adj;
   logic [PK_W-1:0]  pk_word;
   logic             pk_inx, pk_rup;
   logic             inc_zero;

   sprp_inc_sel #(.RND_W(RND_W)) u_inc (
      .mode      (rmode_e'(rnd_mode)),
      .sign      (in_sign),
      .inc       (inc),
      .near_even (near_even)
   );

   sprp_range #(
      .EXP_W(EXP_W), .SIG_W(SIG_W), .RND_W(RND_W),
      .OVF_EXP(OVF_EXP), .BIAS_ADJ(BIAS_ADJ)
   ) u_range (
      .exp_in   (in_exp),
      .sig_in   (in_sig),
      .inc      (inc),
      .unf_mask (unf_mask),
      .ftz_en   (ftz_en),
      .ovf      (r_ovf),
      .flush    (r_flush),
      .unf      (r_unf),
      .exp_adj  (exp_adj),
      .sig_adj  (sig_adj)
   );

   sprp_pack #(
      .EXP_W(EXP_W), .SIG_W(SIG_W), .RND_W(RND_W),
      .FRAC_W(FRAC_W), .PK_W(PK_W)
   ) u_pack (
      .sign        (in_sign),
      .exp_adj     (exp_adj),
      .sig_adj     (sig_adj),
      .inc         (inc),
      .near_even   (near_even),
      .packed_word (pk_word),
      .inexact     (pk_inx),
      .rounded_up  (pk_rup)
   );

   assign inc_zero = (inc == '0);

   always_comb begin
      if (r_ovf) begin
         result   = {in_sign, {EXPF_W{1'b1}}, {FRAC_W{1'b0}}}
                    - {{(PK_W-1){1'b0}}, inc_zero};
         ovf_flag = 1'b1;
         unf_flag = 1'b0;
         inx_flag = (|in_sig[RND_W-1:0]) || ovf_mask;
         rup_flag = inx_flag && !inc_zero;
      end else if (r_flush) begin
         result   = {in_sign, {(PK_W-1){1'b0}}};
         ovf_flag = 1'b0;
         unf_flag = 1'b1;
         inx_flag = 1'b1;
         rup_flag = 1'b0;
      end else begin
         result   = pk_word;
         ovf_flag = 1'b0;
         unf_flag = r_unf;
         inx_flag = pk_inx;
         rup_flag = pk_rup;
      end
   end
endmodule

// File: rtl/sp_round_pack_chk.sv
module sp_round_pack_chk (
   input logic        in_sign,
   input logic [15:0] in_exp,
   input logic [31:0] in_sig,
   input logic [1:0]  rnd_mode,
   input logic        unf_mask,
   input logic        ovf_mask,
   input logic        ftz_en,
   input logic [31:0] result,
   input logic        ovf_flag,
   input logic        unf_flag,
   input logic        inx_flag,
   input logic        rup_flag
);
   always_comb begin
      // R4
      ovf_sat_chk: assert (!ovf_flag ||
         (result[30:23] == 8'hFF && result[22:0] == '0) ||
         (result[30:23] == 8'hFE && (&result[22:0])));
      // R4
      ovf_unf_excl_chk: assert (!(ovf_flag && unf_flag));
      // R5
      ovf_mask_inexact_chk: assert (!(ovf_flag && ovf_mask) || inx_flag);
      // R11
      rup_needs_inexact_chk: assert (!rup_flag || inx_flag);
      // R1
      rz_no_rup_chk: assert (rnd_mode != 2'd3 || !rup_flag);
      // R2
      sign_kept_chk: assert (result[31] == in_sign);
      // R9
      masked_unf_inexact_chk: assert (!(unf_mask && unf_flag) || inx_flag);
      // R10
      flush_zero_chk: assert (!(unf_mask && ftz_en && unf_flag) ||
                              result[30:0] == '0);
      // R7
      bias_normal_chk: assert (!(!unf_mask && unf_flag &&
                                 $signed(in_exp) >= -16'sd192 && in_sig[30]) ||
                               result[30:23] != 8'h00);
   end
endmodule

bind sp_round_pack sp_round_pack_chk u_chk (.*);

// File: tb/sp_round_pack_tb.sv
`timescale 1ns/1ps
module sp_round_pack_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_sign = 1'b0;
   logic [15:0] in_exp = '0;
   logic [31:0] in_sig = '0;
   logic [1:0]  rnd_mode = '0;
   logic        unf_mask = 1'b1;
   logic        ovf_mask = 1'b0;
   logic        ftz_en = 1'b0;
   logic [31:0] result;
   logic        ovf_flag, unf_flag, inx_flag, rup_flag;

   typedef struct {
      logic [35:0] exp_v;
      string       tag;
   } item_t;

   item_t q[$];
   int    n_checks = 0;
   int    n_fails  = 0;
   int    cycles   = 0;
   bit    done     = 0;

   always #2.5 clk = ~clk;

   sp_round_pack u_dut (
      .in_sign(in_sign), .in_exp(in_exp), .in_sig(in_sig),
      .rnd_mode(rnd_mode), .unf_mask(unf_mask), .ovf_mask(ovf_mask),
      .ftz_en(ftz_en), .result(result), .ovf_flag(ovf_flag),
      .unf_flag(unf_flag), .inx_flag(inx_flag), .rup_flag(rup_flag)
   );

   task automatic apply(input logic s, input logic [15:0] e, input logic [31:0] g,
                        input logic [1:0] m, input logic um, input logic om,
                        input logic fz, input logic [31:0] r, input logic eo,
                        input logic eu, input logic ei, input logic er,
                        input string tag);
      item_t it;
      @(posedge clk);
      #1;
      in_sign = s; in_exp = e; in_sig = g; rnd_mode = m;
      unf_mask = um; ovf_mask = om; ftz_en = fz;
      it.exp_v = {r, eo, eu, ei, er};
      it.tag   = tag;
      q.push_back(it);
   endtask

   // monitor: compares one queued item per cycle, away from the edge
   always @(negedge clk) begin
      if (q.size() > 0) begin
         item_t it;
         logic [35:0] act;
         it  = q.pop_front();
         act = {result, ovf_flag, unf_flag, inx_flag, rup_flag};
         n_checks++;
         if (act !== it.exp_v) begin
            n_fails++;
            $display("FAIL %s: actual res=%h o/u/i/r=%b expected res=%h o/u/i/r=%b",
                     it.tag, act[35:4], act[3:0], it.exp_v[35:4], it.exp_v[3:0]);
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      // R12 reset state: all-zero inputs give +0, no flags
      apply(0, 16'h0000, 32'h0000_0000, 2'd0, 1, 0, 0, 32'h0000_0000, 0, 0, 0, 0, "R12 zero input");
      repeat (2) @(posedge clk);
      rst_n = 1'b1;
      // R2 exact 1.0
      apply(0, 16'd126, 32'h4000_0000, 2'd0, 1, 0, 0, 32'h3F80_0000, 0, 0, 0, 0, "R2 exact one");
      // R3 ties to even, even and odd kept LSB
      apply(0, 16'd126, 32'h4000_0040, 2'd0, 1, 0, 0, 32'h3F80_0000, 0, 0, 1, 0, "R3 tie even");
      apply(0, 16'd126, 32'h4000_00C0, 2'd0, 1, 0, 0, 32'h3F80_0002, 0, 0, 1, 1, "R3 tie odd");
      // R1/R11 directed modes
      apply(0, 16'd126, 32'h4000_007F, 2'd3, 1, 0, 0, 32'h3F80_0000, 0, 0, 1, 0, "R1 toward zero");
      apply(0, 16'd126, 32'h4000_0001, 2'd2, 1, 0, 0, 32'h3F80_0001, 0, 0, 1, 1, "R11 up positive");
      apply(1, 16'd126, 32'h4000_0001, 2'd2, 1, 0, 0, 32'hBF80_0000, 0, 0, 1, 0, "R1 up negative");
      apply(1, 16'd126, 32'h4000_0001, 2'd1, 1, 0, 0, 32'hBF80_0001, 0, 0, 1, 1, "R11 down negative");
      // R2 carry into exponent
      apply(0, 16'd126, 32'h7FFF_FFC0, 2'd0, 1, 0, 0, 32'h4000_0000, 0, 0, 1, 1, "R2 carry");
      // R4/R5 overflow
      apply(0, 16'h00FD, 32'h7FFF_FFC0, 2'd0, 1, 0, 0, 32'h7F80_0000, 1, 0, 1, 1, "R4 ovf to inf");
      apply(0, 16'h00FE, 32'h4000_0000, 2'd3, 1, 0, 0, 32'h7F7F_FFFF, 1, 0, 0, 0, "R4 ovf max finite");
      apply(0, 16'h00FE, 32'h4000_0000, 2'd3, 1, 1, 0, 32'h7F7F_FFFF, 1, 0, 1, 0, "R5 ovf masked");
      apply(0, 16'h00FD, 32'h4000_0000, 2'd0, 1, 0, 0, 32'h7F00_0000, 0, 0, 0, 0, "R4 boundary no ovf");
      // R6/R9 tiny masked
      apply(0, 16'hFFFF, 32'h4000_0000, 2'd0, 1, 0, 0, 32'h0040_0000, 0, 0, 0, 0, "R9 tiny exact");
      apply(0, 16'hFFFF, 32'h4000_0081, 2'd0, 1, 0, 0, 32'h0040_0001, 0, 1, 1, 1, "R8 jam one bit");
      apply(0, 16'hFFFF, 32'h7FFF_FFC0, 2'd0, 1, 0, 0, 32'h0080_0000, 0, 0, 1, 1, "R6 not tiny");
      // R10 flush to zero
      apply(1, 16'hFFFF, 32'h4000_0000, 2'd0, 1, 0, 1, 32'h8000_0000, 0, 1, 1, 0, "R10 flush");
      // R7 unmasked bias
      apply(0, 16'hFFFF, 32'h4000_0000, 2'd0, 0, 0, 0, 32'h6000_0000, 0, 1, 0, 0, "R7 bias");
      // R8 long shift keeps sticky
      apply(0, 16'hFFD8, 32'h4000_0000, 2'd2, 1, 0, 0, 32'h0000_0001, 0, 1, 1, 1, "R8 deep jam");
      apply(0, 16'hFED4, 32'h4000_0000, 2'd3, 0, 0, 0, 32'h0000_0000, 0, 1, 1, 0, "R7 bias still negative");
      while (q.size() > 0) @(posedge clk);
      @(posedge clk);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule